// File: doc/BRIEF.md
# Banked Register File with Absolute Access

This block is a 32-byte register store split into four banks of eight 8-bit registers. Every location can be reached in two ways. A short, bank-relative access names one of eight registers with a 3-bit number, and the currently active bank decides which physical location that number means. A long, absolute access names any of the 32 locations with a 5-bit address, whatever bank is active.

The block has one synchronous write port and two combinational read ports. Each port carries its own mode bit, so it can use either form of addressing on any cycle. A separate 2-bit bank register, loaded through its own enable and data pins, selects the active bank. Code that reaches the same few registers often can switch banks and use short register numbers. Code that needs a location in another bank can still reach it through an absolute access.

Top module: `banked_regfile`

## Requirements
- R1: After reset every one of the 32 locations reads 0x00 and the active bank is 0.
- R2: A port in register mode (mode bit 0) resolves its 3-bit number n to the physical address bank*8 + n, which is the concatenation {bank[1:0], n[2:0]}.
- R3: A port in absolute mode (mode bit 1) uses its 5-bit address directly, and the active bank has no effect on it.
- R4: The bank register loads `bank_wdata` on a rising clock edge when `bank_we` is 1, and holds its value when `bank_we` is 0. A register-mode access made in the same cycle as a bank load still uses the old bank. The new bank applies from the next cycle.
- R5: A write with `wr_en` at 1 stores `wr_data` at the resolved address on the rising clock edge. When `wr_en` is 0, no location changes.
- R6: A read of the location being written in the same cycle returns the value held before the edge.
- R7: Changing the bank or writing one location leaves every other location at its stored value.
- R8: A register-mode write to R3 in bank 2 reads back at absolute address 0x13. An absolute write to 0x13 reads back as R3 while bank 2 is active.
- R9: The two read ports resolve their addresses independently, each with its own mode, and can read different locations in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Load enable for the bank register |
| bank_wdata | input | 2 | New active bank |
| wr_en | input | 1 | Write enable for the store |
| wr_mode | input | 1 | Write addressing mode: 0 register, 1 absolute |
| wr_idx | input | 3 | Bank-relative register number for the write |
| wr_abs | input | 5 | Absolute address for the write |
| wr_data | input | 8 | Write data |
| rd0_mode | input | 1 | Read port 0 addressing mode |
| rd0_idx | input | 3 | Read port 0 register number |
| rd0_abs | input | 5 | Read port 0 absolute address |
| rd0_data | output | 8 | Read port 0 data (combinational) |
| rd1_mode | input | 1 | Read port 1 addressing mode |
| rd1_idx | input | 3 | Read port 1 register number |
| rd1_abs | input | 5 | Read port 1 absolute address |
| rd1_data | output | 8 | Read port 1 data (combinational) |

## Verification
The bench fills the store through register-mode writes in every bank and then sweeps all 32 locations through absolute reads. A design that swapped the bank and index fields, or ignored the bank, would return values from the wrong locations. It also loads a new bank and issues a register-mode write in the same cycle. A design that applied the bank a cycle early would put that write in the new bank. Further cases cover a read of the address being written on the same edge, which must show the old byte and not forward the new one, and absolute accesses made while a non-zero bank is active, which catch a design that adds the bank to absolute addresses. Writes and bank loads with their enables low must leave both the store and the bank unchanged.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  typedef enum logic {
    MODE_REG = 1'b0,
    MODE_ABS = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/bank_select.sv
module bank_select #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] load_val,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= load_val;
  end

  p_bank_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bank_q == $past(load_val));
  p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank_q));
endmodule

// File: rtl/addr_resolve.sv
module addr_resolve
  import bankrf_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int IDX_W  = 3,
  localparam int ADDR_W = BANK_W + IDX_W
) (
  input  logic              mode,
  input  logic [BANK_W-1:0] bank,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] abs_addr,
  output logic [ADDR_W-1:0] phys
);
  function automatic logic [ADDR_W-1:0] phys_of(
    input acc_mode_e         m,
    input logic [BANK_W-1:0] b,
    input logic [IDX_W-1:0]  n,
    input logic [ADDR_W-1:0] a
  );
    if (m == MODE_ABS) return a;
    return {b, n};
  endfunction

  always_comb phys = phys_of(acc_mode_e'(mode), bank, idx, abs_addr);
endmodule

// File: rtl/reg_store.sv
module reg_store #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int NUM_RD = 2,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_data[r] = store[rd_addr[r]];

    p_no_write_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!wr_en) && $stable(rd_addr[r])) |-> $stable(rd_data[r]));
  end

  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> store[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankrf_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int REGS_PER_BANK = 8,
  parameter int DATA_W        = 8,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int IDX_W  = $clog2(REGS_PER_BANK),
  localparam int ADDR_W = BANK_W + IDX_W,
  localparam int NPORT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              wr_en,
  input  logic              wr_mode,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_abs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd0_mode,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [ADDR_W-1:0] rd0_abs,
  output logic [DATA_W-1:0] rd0_data,
  input  logic              rd1_mode,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [ADDR_W-1:0] rd1_abs,
  output logic [DATA_W-1:0] rd1_data
);
  logic [BANK_W-1:0] bank_q;

  // Port 0 is the write port, ports 1 and 2 are read ports 0 and 1
  logic [NPORT-1:0]             port_mode;
  logic [NPORT-1:0][IDX_W-1:0]  port_idx;
  logic [NPORT-1:0][ADDR_W-1:0] port_abs;
  logic [NPORT-1:0][ADDR_W-1:0] port_phys;

  assign port_mode = {rd1_mode, rd0_mode, wr_mode};
  assign port_idx  = {rd1_idx,  rd0_idx,  wr_idx};
  assign port_abs  = {rd1_abs,  rd0_abs,  wr_abs};

  bank_select #(.BANK_W(BANK_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bank_we),
    .load_val (bank_wdata),
    .bank_q   (bank_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    addr_resolve #(.BANK_W(BANK_W), .IDX_W(IDX_W)) u_res (
      .mode     (port_mode[p]),
      .bank     (bank_q),
      .idx      (port_idx[p]),
      .abs_addr (port_abs[p]),
      .phys     (port_phys[p])
    );

    p_reg_mode_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (port_mode[p] == MODE_REG) |->
        (port_phys[p][ADDR_W-1:IDX_W] == bank_q && port_phys[p][IDX_W-1:0] == port_idx[p]));
    p_abs_ignores_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (port_mode[p] == MODE_ABS) |-> port_phys[p] == port_abs[p]);
  end

  logic [1:0][DATA_W-1:0] rd_bus;

  reg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RD(2)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (port_phys[0]),
    .wr_data (wr_data),
    .rd_addr ({port_phys[2], port_phys[1]}),
    .rd_data (rd_bus)
  );

  assign rd0_data = rd_bus[0];
  assign rd1_data = rd_bus[1];
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank_we = 0;
  logic [1:0] bank_wdata = 0;
  logic wr_en = 0, wr_mode = 0;
  logic [2:0] wr_idx = 0;
  logic [4:0] wr_abs = 0;
  logic [7:0] wr_data = 0;
  logic rd0_mode = 1, rd1_mode = 1;
  logic [2:0] rd0_idx = 0, rd1_idx = 0;
  logic [4:0] rd0_abs = 0, rd1_abs = 0;
  logic [7:0] rd0_data, rd1_data;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [32];
  int bank_m = 0;

  always #2 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_idx(wr_idx), .wr_abs(wr_abs), .wr_data(wr_data),
    .rd0_mode(rd0_mode), .rd0_idx(rd0_idx), .rd0_abs(rd0_abs), .rd0_data(rd0_data),
    .rd1_mode(rd1_mode), .rd1_idx(rd1_idx), .rd1_abs(rd1_abs), .rd1_data(rd1_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_a(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction
  function automatic logic [7:0] pat_b(input int a);
    return 8'((a * 53 + 200) & 255);
  endfunction

  task automatic set_bank(input int b);
    @(negedge clk); bank_we = 1; bank_wdata = 2'(b);
    @(negedge clk); bank_we = 0; bank_m = b;
  endtask

  task automatic write_reg(input int n, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_mode = 0; wr_idx = 3'(n); wr_data = d;
    @(negedge clk); wr_en = 0; model[bank_m * 8 + n] = d;
  endtask

  task automatic write_abs(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_mode = 1; wr_abs = 5'(a); wr_data = d;
    @(negedge clk); wr_en = 0; model[a] = d;
  endtask

  task automatic read_abs0(input string req, input int a);
    rd0_mode = 1; rd0_abs = 5'(a); #0.5;
    check(req, rd0_data, model[a]);
  endtask

  task automatic read_reg0(input string req, input int n);
    rd0_mode = 0; rd0_idx = 3'(n); #0.5;
    check(req, rd0_data, model[bank_m * 8 + n]);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    #9 rst_n = 1;
    @(negedge clk);

    // R1: reset state on both read ports
    for (int a = 0; a < 32; a++) begin
      read_abs0("R1 reset clear", a);
      rd1_mode = 1; rd1_abs = 5'(31 - a); #0.5;
      check("R1 reset clear port1", rd1_data, 8'h00);
    end

    // R1: bank is 0 after reset; write R5 by register mode, read abs 0x05
    write_reg(5, 8'h3C);
    rd0_mode = 1; rd0_abs = 5'd5; #0.5;
    check("R1 reset bank 0", rd0_data, 8'h3C);

    // R2: fill every bank through register mode, then sweep absolute reads
    for (int b = 0; b < 4; b++) begin
      set_bank(b);
      for (int n = 0; n < 8; n++) write_reg(n, pat_a(b * 8 + n));
    end
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      rd0_mode = 1; rd0_abs = 5'(a); #0.5;
      check("R2 reg write seen at bank*8+n", rd0_data, pat_a(a));
    end

    // R9 and R2: register-mode reads per bank on port 0, absolute reads on port 1
    for (int b = 0; b < 4; b++) begin
      set_bank(b);
      for (int n = 0; n < 8; n++) begin
        read_reg0("R2 reg read resolves bank", n);
        rd1_mode = 1; rd1_abs = 5'((b * 8 + n + 13) % 32); #0.5;
        check("R9 independent port1", rd1_data, model[(b * 8 + n + 13) % 32]);
        rd1_mode = 0; rd1_idx = 3'(7 - n); #0.5;
        check("R9 port1 register mode", rd1_data, model[b * 8 + 7 - n]);
      end
    end

    // R3: absolute writes and reads with bank 1 active
    set_bank(1);
    for (int a = 0; a < 32; a++) write_abs(a, pat_b(a));
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      read_abs0("R3 absolute ignores bank", a);
    end
    for (int b = 0; b < 4; b++) begin
      set_bank(b);
      for (int n = 0; n < 8; n++) read_reg0("R3 abs write seen via reg mode", n);
    end

    // R8: aliasing of bank 2 R3 with absolute 0x13
    set_bank(2);
    write_reg(3, 8'h5A);
    rd0_mode = 1; rd0_abs = 5'h13; #0.5;
    check("R8 reg write at abs 0x13", rd0_data, 8'h5A);
    write_abs(5'h13, 8'hA5);
    rd0_mode = 0; rd0_idx = 3'd3; #0.5;
    check("R8 abs write at bank2 R3", rd0_data, 8'hA5);

    // R7: the other banks keep their R3
    for (int b = 0; b < 4; b++) begin
      if (b != 2) begin
        rd0_mode = 1; rd0_abs = 5'(b * 8 + 3); #0.5;
        check("R7 other banks untouched", rd0_data, model[b * 8 + 3]);
      end
    end

    // R4: bank load and register-mode write on the same edge use the old bank
    @(negedge clk);
    bank_we = 1; bank_wdata = 2'd3;
    wr_en = 1; wr_mode = 0; wr_idx = 3'd0; wr_data = 8'hE1;
    @(negedge clk);
    bank_we = 0; wr_en = 0;
    model[2 * 8 + 0] = 8'hE1; bank_m = 3;
    rd0_mode = 1; rd0_abs = 5'h10; #0.5;
    check("R4 same-cycle write uses old bank", rd0_data, 8'hE1);
    rd0_abs = 5'h18; #0.5;
    check("R4 new bank not written early", rd0_data, model[24]);
    read_reg0("R4 new bank active next cycle", 0);

    // R4: bank_we low holds the bank even if data changes
    @(negedge clk); bank_we = 0; bank_wdata = 2'd1;
    @(negedge clk);
    read_reg0("R4 bank held when load low", 6);

    // R6: read of the location being written returns the old value
    @(negedge clk);
    wr_en = 1; wr_mode = 1; wr_abs = 5'd9; wr_data = 8'h77;
    rd0_mode = 1; rd0_abs = 5'd9;
    rd1_mode = 0; rd1_idx = 3'd1; #0.5;
    check("R6 read during write port0 old", rd0_data, model[9]);
    check("R6 read during write port1 old", rd1_data, model[3 * 8 + 1]);
    @(negedge clk);
    wr_en = 0; model[9] = 8'h77; #0.5;
    check("R5 write visible after edge", rd0_data, 8'h77);

    // R5: wr_en low leaves the store unchanged
    @(negedge clk);
    wr_en = 0; wr_mode = 1; wr_abs = 5'd9; wr_data = 8'h00;
    @(negedge clk);
    @(negedge clk);
    for (int a = 0; a < 32; a++) read_abs0("R5 no write when disabled", a);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule